// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital controller that sits between software and a multi-channel analog-to-digital converter core. Software programs a small control word: a 2-bit conversion mode, a channel number and a start bit. The sequencer then chooses the channel, sends one start-conversion pulse per conversion to the core and waits for the core's done strobe. It stores each result together with the channel it came from and raises a one-cycle end-of-conversion interrupt.

There are four modes. Two use one fixed channel, either once or repeating. Two scan downward from the programmed channel to channel 0, either once or repeating. A control write made while a conversion is running does not break into it. In a fixed-channel mode the new settings take effect at the next conversion boundary. In a scan mode they take effect only after channel 0 has been converted. One case is an exception. If software switches a fixed-channel conversion of channel n to a scan mode, the sequencer keeps going downward from n-1 to 0.

The control word is write-through. A write that sets the start bit while the block is idle launches a conversion on the same clock edge that takes the write.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Mode code 00 with start set converts the programmed channel exactly once and then returns to idle. A channel number above NUM_CH-1 is clamped to NUM_CH-1.
- R2: `conv_req` is a one-cycle pulse. When the block is idle it is issued on the clock edge that takes a write with start set. `busy` is high from that edge up to the edge that records the last result of the run, and it falls only on an edge that also raises `eoc_irq`.
- R3: Each done strobe that follows a request loads `conv_data` into `res_data` and the converted channel into `res_chan`, and it pulses `eoc_irq` high for exactly one cycle.
- R4: Mode code 10 with start set converts channels n, n-1, … down to 0, where n is the programmed channel, and then goes idle.
- R5: Mode code 01 repeats the programmed channel. Once start is cleared, the conversion already running finishes and the block goes idle.
- R6: Mode code 11 restarts the scan from the programmed top channel after every channel 0. Once start is cleared, the sequence already running is completed down to channel 0 before the block goes idle.
- R7: A write with start clear, in any mode including 10 and 11, starts no conversion while the block is idle.
- R8: In a fixed-channel mode, a channel or mode written during a conversion does not change that conversion. It applies from the next conversion on.
- R9: During a scan, writes to the mode, the channel or start do not alter the sequence before channel 0 has been converted. After channel 0 the new settings apply.
- R10: If the mode is changed to 10 while channel n is being converted in a fixed-channel mode, channels n-1 down to 0 follow, regardless of the newly written channel number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_mode | input | 2 | Mode: 00 fixed once, 01 fixed repeat, 10 scan once, 11 scan repeat |
| cfg_chan | input | CH_W | Programmed channel number |
| cfg_start | input | 1 | Start bit; clearing it stops a repeating run at its boundary |
| conv_done | input | 1 | One-cycle done strobe from the converter core |
| conv_data | input | RES_W | Conversion result from the core, valid with `conv_done` |
| conv_chan | output | CH_W | Channel select to the core |
| conv_req | output | 1 | Start-conversion pulse to the core |
| busy | output | 1 | A conversion run is in progress |
| res_data | output | RES_W | Last conversion result |
| res_chan | output | CH_W | Channel tag of the last result |
| eoc_irq | output | 1 | End-of-conversion interrupt pulse |

## Verification
The bench concentrates on writes that land in the middle of a run. A scan interrupted by a mode change must finish down to channel 0 before the new mode runs; a design that applied the change at once would cut the scan short. A fixed conversion switched to scan mode must continue downward from the current channel; a wrong design would either stop or restart at the newly written channel. Clearing start must let a repeating scan run out to channel 0 rather than stop at the next conversion. A scan mode written without start must leave the block idle, where a faulty design would begin a spurious scan.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        MODE_FIX_ONE  = 2'b00,
        MODE_FIX_RUN  = 2'b01,
        MODE_SCAN_ONE = 2'b10,
        MODE_SCAN_RUN = 2'b11
    } seq_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } seq_state_e;

    function automatic logic is_scan(seq_mode_e m);
        return m[1];
    endfunction

    function automatic logic is_repeat(seq_mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CH_W   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [1:0]      wr_mode,
    input  logic [CH_W-1:0] wr_chan,
    input  logic            wr_start,
    input  logic            clr_start,
    output seq_mode_e       eff_mode,
    output logic [CH_W-1:0] eff_chan,
    output logic            eff_start
);

    typedef struct packed {
        seq_mode_e       mode;
        logic [CH_W-1:0] chan;
        logic            start;
    } cfg_t;

    cfg_t            cfg_q, cfg_d, eff;
    logic [CH_W-1:0] chan_lim;

    // clamp only when the channel field can encode more channels than exist
    generate
        if (NUM_CH == (1 << CH_W)) begin : g_full
            assign chan_lim = wr_chan;
        end else begin : g_clamp
            localparam logic [CH_W-1:0] TOP_CH = CH_W'(NUM_CH - 1);
            assign chan_lim = (wr_chan > TOP_CH) ? TOP_CH : wr_chan;
        end
    endgenerate

    always_comb begin
        eff = cfg_q;
        if (wr) begin
            eff.mode  = seq_mode_e'(wr_mode);
            eff.chan  = chan_lim;
            eff.start = wr_start;
        end
        cfg_d = eff;
        if (clr_start) begin
            cfg_d.start = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{mode: MODE_FIX_ONE, chan: '0, start: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign eff_mode  = eff.mode;
    assign eff_chan  = eff.chan;
    assign eff_start = eff.start;

endmodule

// File: rtl/adc_seq_step.sv
module adc_seq_step
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  seq_mode_e       act_mode,
    input  logic [CH_W-1:0] cur_ch,
    input  seq_mode_e       eff_mode,
    input  logic [CH_W-1:0] eff_chan,
    input  logic            eff_start,
    output logic            go,
    output logic [CH_W-1:0] nxt_ch,
    output seq_mode_e       nxt_mode,
    output logic            clr_start
);

    logic at_bottom;
    assign at_bottom = (cur_ch == '0);

    always_comb begin
        go        = 1'b0;
        nxt_ch    = cur_ch;
        nxt_mode  = act_mode;
        clr_start = 1'b0;
        if (is_scan(act_mode) && !at_bottom) begin
            // inside a scan: settings are held off until channel 0
            go     = 1'b1;
            nxt_ch = cur_ch - 1'b1;
        end else if (!eff_start) begin
            go = 1'b0;
        end else if (!is_scan(act_mode) && is_scan(eff_mode) && !at_bottom) begin
            // fixed conversion switched to scan: continue downward
            go       = 1'b1;
            nxt_ch   = cur_ch - 1'b1;
            nxt_mode = eff_mode;
        end else if ((eff_mode == act_mode) && !is_repeat(eff_mode)) begin
            // one-shot run complete
            clr_start = 1'b1;
        end else begin
            go       = 1'b1;
            nxt_ch   = eff_chan;
            nxt_mode = eff_mode;
        end
    end

endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
    parameter int CH_W  = 4,
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [RES_W-1:0] data_in,
    input  logic [CH_W-1:0]  chan_in,
    output logic [RES_W-1:0] res_data,
    output logic [CH_W-1:0]  res_chan,
    output logic             eoc
);

    typedef struct packed {
        logic [RES_W-1:0] data;
        logic [CH_W-1:0]  chan;
        logic             eoc;
    } res_t;

    res_t res_q, res_d;

    always_comb begin
        res_d     = res_q;
        res_d.eoc = capture;
        if (capture) begin
            res_d.data = data_in;
            res_d.chan = chan_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_data = res_q.data;
    assign res_chan = res_q.chan;
    assign eoc      = res_q.eoc;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int RES_W  = 12,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_mode,
    input  logic [CH_W-1:0]  cfg_chan,
    input  logic             cfg_start,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    output logic [CH_W-1:0]  conv_chan,
    output logic             conv_req,
    output logic             busy,
    output logic [RES_W-1:0] res_data,
    output logic [CH_W-1:0]  res_chan,
    output logic             eoc_irq
);

    typedef struct packed {
        seq_state_e      st;
        seq_mode_e       act;
        logic [CH_W-1:0] ch;
        logic            req;
    } seq_t;

    seq_t            seq_q, seq_d;
    seq_mode_e       eff_mode, nxt_mode;
    logic [CH_W-1:0] eff_chan, nxt_ch;
    logic            eff_start, step_go, step_clr;
    logic            done_take, capture, clr_start;

    adc_seq_cfg #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .wr_mode   (cfg_mode),
        .wr_chan   (cfg_chan),
        .wr_start  (cfg_start),
        .clr_start (clr_start),
        .eff_mode  (eff_mode),
        .eff_chan  (eff_chan),
        .eff_start (eff_start)
    );

    adc_seq_step #(.CH_W(CH_W)) u_step (
        .act_mode  (seq_q.act),
        .cur_ch    (seq_q.ch),
        .eff_mode  (eff_mode),
        .eff_chan  (eff_chan),
        .eff_start (eff_start),
        .go        (step_go),
        .nxt_ch    (nxt_ch),
        .nxt_mode  (nxt_mode),
        .clr_start (step_clr)
    );

    adc_seq_result #(.CH_W(CH_W), .RES_W(RES_W)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .data_in  (conv_data),
        .chan_in  (seq_q.ch),
        .res_data (res_data),
        .res_chan (res_chan),
        .eoc      (eoc_irq)
    );

    // a done strobe in the request cycle cannot belong to this request
    assign done_take = (seq_q.st == ST_CONV) && conv_done && !seq_q.req;
    assign clr_start = done_take && step_clr;

    always_comb begin
        seq_d     = seq_q;
        seq_d.req = 1'b0;
        capture   = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (eff_start) begin
                    seq_d.st  = ST_CONV;
                    seq_d.ch  = eff_chan;
                    seq_d.act = eff_mode;
                    seq_d.req = 1'b1;
                end
            end
            ST_CONV: begin
                if (done_take) begin
                    capture = 1'b1;
                    if (step_go) begin
                        seq_d.ch  = nxt_ch;
                        seq_d.act = nxt_mode;
                        seq_d.req = 1'b1;
                    end else begin
                        seq_d.st = ST_IDLE;
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, act: MODE_FIX_ONE, ch: '0, req: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign conv_chan = seq_q.ch;
    assign conv_req  = seq_q.req;
    assign busy      = (seq_q.st == ST_CONV);

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int CH_W  = 4,
    parameter int RES_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_wr,
    input logic [CH_W-1:0] conv_chan,
    input logic            conv_req,
    input logic            busy,
    input logic [CH_W-1:0] res_chan,
    input logic            eoc_irq
);

    // R2
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    // R2
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> busy);

    // R2
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> eoc_irq);

    // R3
    eoc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq |=> !eoc_irq);

    // R3
    res_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq |-> (res_chan == $past(conv_chan)));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cfg_wr) |=> !busy);

endmodule

bind adc_seq_ctrl adc_seq_chk #(.CH_W(CH_W), .RES_W(RES_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .conv_chan (conv_chan),
    .conv_req  (conv_req),
    .busy      (busy),
    .res_chan  (res_chan),
    .eoc_irq   (eoc_irq)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;

    localparam int NUM_CH = 16;
    localparam int RES_W  = 12;
    localparam int CH_W   = 4;
    localparam int LAT    = 4;
    localparam int LOGN   = 512;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [1:0]       cfg_mode = 2'b00;
    logic [CH_W-1:0]  cfg_chan = '0;
    logic             cfg_start = 1'b0;
    logic             conv_done;
    logic [RES_W-1:0] conv_data;
    logic [CH_W-1:0]  conv_chan;
    logic             conv_req, busy, eoc_irq;
    logic [RES_W-1:0] res_data;
    logic [CH_W-1:0]  res_chan;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    adc_seq_ctrl #(.NUM_CH(NUM_CH), .RES_W(RES_W)) i_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
        .cfg_chan(cfg_chan), .cfg_start(cfg_start), .conv_done(conv_done),
        .conv_data(conv_data), .conv_chan(conv_chan), .conv_req(conv_req),
        .busy(busy), .res_data(res_data), .res_chan(res_chan), .eoc_irq(eoc_irq)
    );

    function automatic logic [RES_W-1:0] model_data(logic [CH_W-1:0] ch);
        return RES_W'(int'(ch) * 181 + 7);
    endfunction

    // converter core model: fixed latency after each request
    int              lat_cnt;
    logic [CH_W-1:0] lat_ch;
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (!rst_n) begin
            lat_cnt   <= 0;
            conv_data <= '0;
        end else if (conv_req) begin
            lat_cnt <= LAT;
            lat_ch  <= conv_chan;
        end else if (lat_cnt != 0) begin
            lat_cnt <= lat_cnt - 1;
            if (lat_cnt == 1) begin
                conv_done <= 1'b1;
                conv_data <= model_data(lat_ch);
            end
        end
    end

    // result monitor
    logic [CH_W-1:0] log_ch [LOGN];
    int n_log = 0;
    int data_bad = 0;
    always @(negedge clk) begin
        if (rst_n && eoc_irq) begin
            if (n_log < LOGN) log_ch[n_log] <= res_chan;
            if (res_data != model_data(res_chan)) data_bad <= data_bad + 1;
            n_log <= n_log + 1;
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_tests = n_tests + 1;
            n_fail  = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests = n_tests + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [1:0] m, input int ch, input logic st);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_mode  = m;
        cfg_chan  = CH_W'(ch);
        cfg_start = st;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_eocs(input int target);
        for (int i = 0; i < 4000 && n_log < target; i++) @(negedge clk);
    endtask

    task automatic wait_req();
        for (int i = 0; i < 200 && !conv_req; i++) @(negedge clk);
        @(negedge clk);
    endtask

    // {mode, channel, expected conversion count}
    localparam logic [10:0] VEC [6] = '{
        {2'b00, 4'd5,  5'd1},
        {2'b10, 4'd3,  5'd4},
        {2'b10, 4'd0,  5'd1},
        {2'b00, 4'd15, 5'd1},
        {2'b10, 4'd15, 5'd16},
        {2'b00, 4'd0,  5'd1}
    };

    initial begin
        int base, bad, cnt;
        repeat (3) @(negedge clk);
        // reset state
        check(!busy && !conv_req && !eoc_irq && res_data == '0 && res_chan == '0,
              "R2 reset outputs", int'(busy), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table of one-shot runs
        for (int v = 0; v < 6; v++) begin
            logic [1:0] m;
            int ch, exp_n;
            m     = VEC[v][10:9];
            ch    = int'(VEC[v][8:5]);
            exp_n = int'(VEC[v][4:0]);
            base  = n_log;
            write_cfg(m, ch, 1'b1);
            wait_idle();
            check(n_log - base == exp_n, m[1] ? "R4 scan count" : "R1 fixed count",
                  n_log - base, exp_n);
            bad = 0;
            for (int i = 0; i < exp_n; i++) begin
                int e;
                e = m[1] ? ch - i : ch;
                if (int'(log_ch[base + i]) != e) bad++;
            end
            check(bad == 0, m[1] ? "R4 scan order" : "R1 fixed channel", bad, 0);
        end

        // R2 request and busy timing
        write_cfg(2'b00, 7, 1'b1);
        check(conv_req && busy && conv_chan == 4'd7, "R2 req on write edge", int'(conv_req), 1);
        @(negedge clk);
        check(!conv_req && busy, "R2 req single pulse", int'(conv_req), 0);
        wait_idle();

        // R7 scan mode without start stays idle
        base = n_log;
        write_cfg(2'b11, 6, 1'b0);
        repeat (20) @(negedge clk);
        check(!busy && n_log == base, "R7 no start no conversion", n_log - base, 0);
        write_cfg(2'b10, 9, 1'b0);
        repeat (20) @(negedge clk);
        check(!busy && n_log == base, "R7 scan single no start", n_log - base, 0);

        // R5 fixed repeat, then clear start
        base = n_log;
        write_cfg(2'b01, 4, 1'b1);
        wait_eocs(base + 3);
        write_cfg(2'b01, 4, 1'b0);
        wait_idle();
        cnt = n_log - base;
        bad = 0;
        for (int i = 0; i < cnt; i++) if (log_ch[base + i] != 4'd4) bad++;
        check(cnt >= 3 && cnt <= 5 && bad == 0 && !busy, "R5 fixed repeat stop", cnt, 4);

        // R8 channel change during fixed repeat applies next conversion
        base = n_log;
        write_cfg(2'b01, 2, 1'b1);
        @(negedge clk);
        write_cfg(2'b01, 9, 1'b1);
        wait_eocs(base + 3);
        write_cfg(2'b01, 9, 1'b0);
        wait_idle();
        check(log_ch[base] == 4'd2, "R8 current conversion kept", int'(log_ch[base]), 2);
        check(log_ch[base + 1] == 4'd9 && log_ch[base + 2] == 4'd9, "R8 new channel next",
              int'(log_ch[base + 1]), 9);

        // R9 mode change during scan deferred to channel 0
        base = n_log;
        write_cfg(2'b10, 5, 1'b1);
        @(negedge clk);
        write_cfg(2'b00, 12, 1'b1);
        wait_idle();
        bad = 0;
        for (int i = 0; i < 6; i++) if (int'(log_ch[base + i]) != 5 - i) bad++;
        check(n_log - base == 7 && bad == 0, "R9 scan completes first", n_log - base, 7);
        check(log_ch[base + 6] == 4'd12, "R9 new setting after ch0", int'(log_ch[base + 6]), 12);

        // R10 fixed to scan switch continues downward
        base = n_log;
        write_cfg(2'b00, 3, 1'b1);
        @(negedge clk);
        write_cfg(2'b10, 7, 1'b1);
        wait_idle();
        bad = 0;
        for (int i = 0; i < 4; i++) if (int'(log_ch[base + i]) != 3 - i) bad++;
        check(n_log - base == 4 && bad == 0, "R10 continue n-1 to 0", n_log - base, 4);

        // R6 scan repeat, clear start mid-sequence
        base = n_log;
        write_cfg(2'b11, 2, 1'b1);
        wait_eocs(base + 5);
        write_cfg(2'b11, 2, 1'b0);
        wait_idle();
        cnt = n_log - base;
        bad = 0;
        for (int i = 0; i < cnt; i++) if (int'(log_ch[base + i]) != 2 - (i % 3)) bad++;
        check(cnt == 6 && bad == 0 && !busy, "R6 scan repeat finishes sequence", cnt, 6);

        // R1 clamp is a no-op at full width; out of range cannot be driven here
        // R3 data and tag of every result
        check(data_bad == 0, "R3 result data", data_bad, 0);
        check(res_chan == 4'd0 && res_data == model_data(4'd0), "R3 last result held",
              int'(res_data), int'(model_data(4'd0)));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule